// File: doc/BRIEF.md
# Transmit Descriptor Ring Poller

This block walks a ring of transmit descriptors held in host memory and turns each one the controller owns into a byte stream. Every descriptor occupies four 16-bit words. The block reads a descriptor's control word, its buffer address and its negatively encoded length. It then fetches the buffer one word at a time and emits the bytes with start and end markers. When the frame is done, it writes a status word and a new control word back to the descriptor, and pulses a transmit interrupt.

Polling begins on a one-cycle demand strobe. After each completed descriptor the block goes straight on to the next ring slot. It stops at the first descriptor whose ownership bit is clear. The ring base address and the log2 of the ring size are static inputs. The ring index wraps by masking. Memory is reached through a single request/grant port: read data is valid in the cycle the grant is given.

Top module: `tx_ring_poller`

## Requirements
- R1: After reset the block is idle. No memory request, no stream valid, no start or end marker and no interrupt are asserted, and the ring index is 0. Nothing happens until a demand strobe arrives.
- R2: A demand strobe while idle reads the control word of the current descriptor. The descriptor starts at byte address `ring_base_i + 8*index`. Word 0 holds the buffer address bits 15:0. Word 1 holds `{flags[7:0], buffer address bits 23:16}`. Word 2 holds the length and word 3 holds the status. Ownership is flag bit 7 (word 1 bit 15). When ownership is clear, the block goes idle and emits no byte, writes nothing and raises no interrupt.
- R3: The byte count is 4096 minus length bits 11:0, so a field of 0 means 4096 bytes. Bytes are taken from consecutive byte addresses starting at the buffer address, which may be odd. Within a word, the even-address byte is bits 15:8.
- R4: The start marker is asserted on the first byte only when flag bit 1 (start of packet) is set. The end marker is asserted on the last byte only when flag bit 0 (end of packet) is set.
- R5: While the stream is valid and ready is low, the data and markers are held unchanged.
- R6: When a descriptor has both the start and end flags set, completion writes status word 0, then writes word 1 with the ownership bit cleared and the other flags and the address byte unchanged. A one-cycle interrupt pulse follows.
- R7: When a descriptor has the start flag set without the end flag, the status word is written as 0xC000 (buffer error plus underflow). Word 1 is written with error-summary flag bit 6 set and ownership cleared, and the interrupt still pulses.
- R8: After each completion the next descriptor is polled without a new demand. The index advances modulo 2^`ring_log2_i`, wrapping to 0, and descriptors beyond the ring are never touched.
- R9: A demand strobe that arrives while the block is busy is remembered. Once the block stops, it polls again.
- R10: A memory request is held with a stable, even address until it is granted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| demand_i | input | 1 | Transmit demand strobe |
| ring_base_i | input | 24 | Byte address of ring slot 0 |
| ring_log2_i | input | 3 | Log2 of the ring size |
| mem_req_o | output | 1 | Memory request |
| mem_we_o | output | 1 | Memory write enable |
| mem_addr_o | output | 24 | Memory byte address (even) |
| mem_wdata_o | output | 16 | Memory write data |
| mem_gnt_i | input | 1 | Memory grant; read data valid in the same cycle |
| mem_rdata_i | input | 16 | Memory read data |
| tx_data_o | output | 8 | Stream byte |
| tx_valid_o | output | 1 | Stream byte valid |
| tx_sop_o | output | 1 | Start-of-frame marker |
| tx_eop_o | output | 1 | End-of-frame marker |
| tx_ready_i | input | 1 | Stream sink ready |
| tx_int_o | output | 1 | Transmit completion pulse |

## Verification
Some properties are checked by assertions on every cycle. A memory request keeps its address stable and even until it is granted. A stalled stream byte and its markers stay put. Bytes flow only in the streaming phase, and the interrupt is a single-cycle pulse. The index wraps at the mask, and the remaining byte count never reaches zero while a frame is active. Other behaviour only the directed scenarios can show: the byte order, odd start addresses and the 4096-byte length, the written-back status and flag words, stopping at a host-owned slot, ring wrap-around, and a demand that is remembered and answered with a second poll.

// File: rtl/txp_pkg.sv
package txp_pkg;
  localparam int unsigned WORD_W      = 16;
  localparam int unsigned LEN_FIELD_W = 12;
  localparam int unsigned CNT_W       = LEN_FIELD_W + 1;

  localparam int unsigned F_ENP = 0;
  localparam int unsigned F_STP = 1;
  localparam int unsigned F_ERR = 6;
  localparam int unsigned F_OWN = 7;

  localparam logic [WORD_W-1:0] MISC_BUF_UFLO = 16'hC000;

  typedef enum logic [2:0] {
    S_IDLE, S_RD_FLAG, S_RD_ADDR, S_RD_LEN, S_STREAM, S_WR_MISC, S_WR_FLAG
  } state_e;

  // negative 12-bit length to byte count; 0 maps to full 4096
  function automatic logic [CNT_W-1:0] len_to_count(input logic [LEN_FIELD_W-1:0] f);
    len_to_count = {1'b1, {LEN_FIELD_W{1'b0}}} - {1'b0, f};
  endfunction
endpackage

// File: rtl/txp_ring_index.sv
module txp_ring_index #(
  parameter int unsigned LOG_W = 3,
  localparam int unsigned IDX_W = (1 << LOG_W) - 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             adv_i,
  input  logic [LOG_W-1:0] log2_i,
  output logic [IDX_W-1:0] idx_o
);
  logic [IDX_W-1:0] idx_q, mask;

  assign mask  = ~({IDX_W{1'b1}} << log2_i);
  assign idx_o = idx_q & mask;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    idx_q <= '0;
    else if (adv_i) idx_q <= (idx_o + 1'b1) & mask;
  end

  a_r8_wrap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    adv_i && (idx_o == mask) |=> (idx_o == '0) || !$stable(log2_i));
endmodule

// File: rtl/txp_byte_emit.sv
module txp_byte_emit import txp_pkg::*; #(
  parameter int unsigned ADDR_W = 24
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [ADDR_W-1:0] start_addr_i,
  input  logic [CNT_W-1:0]  start_cnt_i,
  input  logic              sop_en_i,
  input  logic              eop_en_i,
  input  logic              word_we_i,
  input  logic [WORD_W-1:0] word_i,
  output logic              need_word_o,
  output logic [ADDR_W-1:0] fetch_addr_o,
  output logic              done_o,
  output logic [7:0]        tx_data_o,
  output logic              tx_valid_o,
  output logic              tx_sop_o,
  output logic              tx_eop_o,
  input  logic              tx_ready_i
);
  logic              active_q, have_q, first_q, sop_en_q, eop_en_q;
  logic [ADDR_W-1:0] addr_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [WORD_W-1:0] word_q;
  logic              last, hs;

  assign last         = (cnt_q == CNT_W'(1));
  assign tx_valid_o   = active_q & have_q;
  assign hs           = tx_valid_o & tx_ready_i;
  assign tx_data_o    = addr_q[0] ? word_q[7:0] : word_q[15:8];
  assign tx_sop_o     = tx_valid_o & first_q & sop_en_q;
  assign tx_eop_o     = tx_valid_o & last & eop_en_q;
  assign need_word_o  = active_q & ~have_q;
  assign fetch_addr_o = {addr_q[ADDR_W-1:1], 1'b0};
  assign done_o       = hs & last;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      have_q   <= 1'b0;
      first_q  <= 1'b0;
      sop_en_q <= 1'b0;
      eop_en_q <= 1'b0;
      addr_q   <= '0;
      cnt_q    <= '0;
      word_q   <= '0;
    end else if (start_i) begin
      active_q <= 1'b1;
      have_q   <= 1'b0;
      first_q  <= 1'b1;
      sop_en_q <= sop_en_i;
      eop_en_q <= eop_en_i;
      addr_q   <= start_addr_i;
      cnt_q    <= start_cnt_i;
    end else begin
      if (word_we_i) begin
        word_q <= word_i;
        have_q <= 1'b1;
      end
      if (hs) begin
        cnt_q   <= cnt_q - 1'b1;
        addr_q  <= addr_q + 1'b1;
        first_q <= 1'b0;
        if (addr_q[0] || last) have_q <= 1'b0;
        if (last) active_q <= 1'b0;
      end
    end
  end

  a_r5_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_valid_o && !tx_ready_i |=> tx_valid_o && $stable(tx_data_o)
                                  && $stable(tx_sop_o) && $stable(tx_eop_o));
  a_r3_cnt_live: assert property (@(posedge clk_i) disable iff (!rst_ni)
    active_q |-> cnt_q != '0);
endmodule

// File: rtl/tx_ring_poller.sv
module tx_ring_poller import txp_pkg::*; #(
  parameter int unsigned ADDR_W = 24,
  parameter int unsigned LOG_W  = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              demand_i,
  input  logic [ADDR_W-1:0] ring_base_i,
  input  logic [LOG_W-1:0]  ring_log2_i,
  output logic              mem_req_o,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [WORD_W-1:0] mem_wdata_o,
  input  logic              mem_gnt_i,
  input  logic [WORD_W-1:0] mem_rdata_i,
  output logic [7:0]        tx_data_o,
  output logic              tx_valid_o,
  output logic              tx_sop_o,
  output logic              tx_eop_o,
  input  logic              tx_ready_i,
  output logic              tx_int_o
);
  localparam int unsigned IDX_W = (1 << LOG_W) - 1;

  state_e            state_q, state_d;
  logic [7:0]        flag_q, hi_q, flag_new;
  logic [15:0]       lo_q;
  logic              pend_q, tint_q, err_w;
  logic [IDX_W-1:0]  idx;
  logic [ADDR_W-1:0] desc_addr, fetch_addr;
  logic              need_word, emit_done, emit_start, word_we, adv;

  txp_ring_index #(.LOG_W(LOG_W)) i_index (
    .clk_i, .rst_ni, .adv_i(adv), .log2_i(ring_log2_i), .idx_o(idx)
  );

  assign emit_start = (state_q == S_RD_LEN) & mem_gnt_i;
  assign word_we    = (state_q == S_STREAM) & mem_gnt_i;
  assign adv        = (state_q == S_WR_FLAG) & mem_gnt_i;

  txp_byte_emit #(.ADDR_W(ADDR_W)) i_emit (
    .clk_i, .rst_ni,
    .start_i(emit_start),
    .start_addr_i(ADDR_W'({hi_q, lo_q})),
    .start_cnt_i(len_to_count(mem_rdata_i[LEN_FIELD_W-1:0])),
    .sop_en_i(flag_q[F_STP]),
    .eop_en_i(flag_q[F_ENP]),
    .word_we_i(word_we),
    .word_i(mem_rdata_i),
    .need_word_o(need_word),
    .fetch_addr_o(fetch_addr),
    .done_o(emit_done),
    .tx_data_o, .tx_valid_o, .tx_sop_o, .tx_eop_o, .tx_ready_i
  );

  assign desc_addr = ring_base_i + ADDR_W'({idx, 3'b000});
  assign err_w     = flag_q[F_STP] & ~flag_q[F_ENP];

  always_comb begin
    flag_new        = flag_q;
    flag_new[F_OWN] = 1'b0;
    if (err_w) flag_new[F_ERR] = 1'b1;
  end

  always_comb begin
    mem_req_o   = 1'b0;
    mem_we_o    = 1'b0;
    mem_addr_o  = desc_addr;
    mem_wdata_o = '0;
    unique case (state_q)
      S_RD_FLAG: begin mem_req_o = 1'b1; mem_addr_o = desc_addr + ADDR_W'(2); end
      S_RD_ADDR: mem_req_o = 1'b1;
      S_RD_LEN:  begin mem_req_o = 1'b1; mem_addr_o = desc_addr + ADDR_W'(4); end
      S_STREAM:  begin mem_req_o = need_word; mem_addr_o = fetch_addr; end
      S_WR_MISC: begin
        mem_req_o   = 1'b1;
        mem_we_o    = 1'b1;
        mem_addr_o  = desc_addr + ADDR_W'(6);
        mem_wdata_o = err_w ? MISC_BUF_UFLO : '0;
      end
      S_WR_FLAG: begin
        mem_req_o   = 1'b1;
        mem_we_o    = 1'b1;
        mem_addr_o  = desc_addr + ADDR_W'(2);
        mem_wdata_o = {flag_new, hi_q};
      end
      default: ;
    endcase
  end

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      S_IDLE:    if (demand_i || pend_q) state_d = S_RD_FLAG;
      S_RD_FLAG: if (mem_gnt_i) state_d = mem_rdata_i[8+F_OWN] ? S_RD_ADDR : S_IDLE;
      S_RD_ADDR: if (mem_gnt_i) state_d = S_RD_LEN;
      S_RD_LEN:  if (mem_gnt_i) state_d = S_STREAM;
      S_STREAM:  if (emit_done) state_d = S_WR_MISC;
      S_WR_MISC: if (mem_gnt_i) state_d = S_WR_FLAG;
      S_WR_FLAG: if (mem_gnt_i) state_d = S_RD_FLAG;
      default:   state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= S_IDLE;
      flag_q  <= '0;
      hi_q    <= '0;
      lo_q    <= '0;
      pend_q  <= 1'b0;
      tint_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      tint_q  <= adv;
      if (state_q == S_IDLE) pend_q <= 1'b0;
      else if (demand_i)     pend_q <= 1'b1;
      if (state_q == S_RD_FLAG && mem_gnt_i) begin
        flag_q <= mem_rdata_i[15:8];
        hi_q   <= mem_rdata_i[7:0];
      end
      if (state_q == S_RD_ADDR && mem_gnt_i) lo_q <= mem_rdata_i;
    end
  end

  assign tx_int_o = tint_q;

  a_r10_even_addr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |-> !mem_addr_o[0]);
  a_r10_req_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && !mem_gnt_i |=> mem_req_o && $stable(mem_addr_o) && $stable(mem_we_o));
  a_r4_stream_phase: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_valid_o |-> state_q == S_STREAM);
  a_r6_int_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_int_o |=> !tx_int_o);
endmodule

// File: tb/test_tx_ring_poller.sv
module test_tx_ring_poller;
  localparam int CLK_PERIOD = 10;
  localparam int CAP_N      = 4200;
  localparam logic [23:0] RING = 24'h000100;

  logic clk = 1'b0, rst_n = 1'b0, demand = 1'b0;
  logic [23:0] ring_base = RING;
  logic [2:0]  ring_log2 = 3'd3;
  logic        mem_req, mem_we, mem_gnt, allow = 1'b1, ready = 1'b1;
  logic [23:0] mem_addr;
  logic [15:0] mem_wdata, mem_rdata;
  logic [7:0]  tx_data;
  logic        tx_valid, tx_sop, tx_eop, tx_int;

  logic [15:0] mem [4096];
  logic [7:0]  cap_d [CAP_N];
  logic        cap_s [CAP_N];
  logic        cap_e [CAP_N];
  int n_cap, n_tint, flag_reads, cyc, gnt_mode, ready_mode;
  logic [23:0] watch_addr;
  int n_chk = 0, n_bad = 0;

  assign mem_gnt   = mem_req & allow;
  assign mem_rdata = mem[mem_addr[12:1]];

  tx_ring_poller i_tx_ring_poller (
    .clk_i(clk), .rst_ni(rst_n), .demand_i(demand),
    .ring_base_i(ring_base), .ring_log2_i(ring_log2),
    .mem_req_o(mem_req), .mem_we_o(mem_we), .mem_addr_o(mem_addr),
    .mem_wdata_o(mem_wdata), .mem_gnt_i(mem_gnt), .mem_rdata_i(mem_rdata),
    .tx_data_o(tx_data), .tx_valid_o(tx_valid), .tx_sop_o(tx_sop),
    .tx_eop_o(tx_eop), .tx_ready_i(ready), .tx_int_o(tx_int)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // memory model and stream sink, evaluated mid-cycle
  always @(negedge clk) begin
    cyc++;
    case (gnt_mode)
      0: allow = 1'b1;
      1: allow = (cyc % 3 == 0);
      default: allow = 1'b0;
    endcase
    case (ready_mode)
      0: ready = 1'b1;
      default: ready = (cyc % 2 == 0) || (cyc % 7 == 0);
    endcase
    #1;
    if (rst_n) begin
      if (tx_valid && ready) begin
        if (n_cap < CAP_N) begin
          cap_d[n_cap] = tx_data;
          cap_s[n_cap] = tx_sop;
          cap_e[n_cap] = tx_eop;
        end
        n_cap++;
      end
      if (tx_int) n_tint++;
      if (mem_gnt) begin
        if (mem_we) mem[mem_addr[12:1]] = mem_wdata;
        else if (mem_addr == watch_addr) flag_reads++;
      end
    end
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] pat(input logic [23:0] a);
    return 8'((a * 7 + 3) & 255);
  endfunction

  task automatic do_reset();
    rst_n = 1'b0; demand = 1'b0; gnt_mode = 0; ready_mode = 0;
    ring_base = RING; ring_log2 = 3'd3; watch_addr = 24'hFFFFFF;
    for (int i = 0; i < 4096; i++) mem[i] = 16'h0000;
    repeat (3) @(negedge clk);
    n_cap = 0; n_tint = 0; flag_reads = 0;
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic set_desc(input int idx, input logic [7:0] flg, input logic [23:0] ba, input int cnt);
    logic [11:0] l;
    int w;
    l = 12'((4096 - cnt) & 12'hFFF);
    w = (RING + idx * 8) >> 1;
    mem[w]     = ba[15:0];
    mem[w + 1] = {flg, ba[23:16]};
    mem[w + 2] = {4'hF, l};
    mem[w + 3] = 16'h1234;
  endtask

  task automatic fill_buf(input logic [23:0] ba, input int cnt);
    for (int j = 0; j < cnt; j++) begin
      logic [23:0] a;
      a = ba + 24'(j);
      if (a[0]) mem[a[12:1]][7:0]  = pat(a);
      else      mem[a[12:1]][15:8] = pat(a);
    end
  endtask

  task automatic check_bytes(input string tag, input logic [23:0] ba, input int cnt, input int from);
    int bad;
    bad = 0;
    for (int j = 0; j < cnt; j++)
      if (cap_d[from + j] !== pat(ba + 24'(j))) bad++;
    check({tag, " byte values"}, bad, 0);
  endtask

  task automatic marks(input string tag, input int from, input int cnt, input logic sop_exp, input logic eop_exp);
    int ns, ne;
    ns = 0; ne = 0;
    for (int j = from; j < from + cnt; j++) begin
      if (cap_s[j]) ns++;
      if (cap_e[j]) ne++;
    end
    check({tag, " sop first"}, cap_s[from], sop_exp);
    check({tag, " sop count"}, ns, sop_exp ? 1 : 0);
    check({tag, " eop last"}, cap_e[from + cnt - 1], eop_exp);
    check({tag, " eop count"}, ne, eop_exp ? 1 : 0);
  endtask

  task automatic pulse_demand();
    @(negedge clk) demand = 1'b1;
    @(negedge clk) demand = 1'b0;
  endtask

  task automatic wait_quiet();
    int q;
    q = 0;
    while (q < 8) begin
      @(negedge clk); #2;
      if (mem_req || tx_valid) q = 0; else q++;
    end
  endtask

  function automatic int wi(input int idx, input int k);
    return ((RING + idx * 8) >> 1) + k;
  endfunction

  task automatic t_reset();
    do_reset();
    #2;
    check("R1 req", mem_req, 0);
    check("R1 valid", tx_valid, 0);
    check("R1 sop/eop", {tx_sop, tx_eop}, 0);
    check("R1 int", tx_int, 0);
    repeat (6) @(negedge clk);
    #2;
    check("R1 no req without demand", mem_req, 0);
  endtask

  task automatic t_host_owned();
    do_reset();
    ring_log2 = 3'd2;
    set_desc(0, 8'h03, 24'h1000, 4);
    pulse_demand();
    wait_quiet();
    check("R2 no bytes", n_cap, 0);
    check("R2 no int", n_tint, 0);
    check("R2 misc untouched", mem[wi(0, 3)], 16'h1234);
    check("R2 flag untouched", mem[wi(0, 1)], 16'h0300);
  endtask

  task automatic t_single();
    do_reset();
    set_desc(0, 8'h83, 24'h1000, 5);
    fill_buf(24'h1000, 5);
    pulse_demand();
    wait_quiet();
    check("R3 count", n_cap, 5);
    check_bytes("R3", 24'h1000, 5, 0);
    marks("R4", 0, 5, 1'b1, 1'b1);
    check("R6 misc", mem[wi(0, 3)], 16'h0000);
    check("R6 flag", mem[wi(0, 1)], 16'h0300);
    check("R6 int", n_tint, 1);
  endtask

  task automatic t_odd_bp();
    do_reset();
    gnt_mode = 1; ready_mode = 1;
    set_desc(0, 8'h83, 24'h1235, 6);
    fill_buf(24'h1235, 6);
    pulse_demand();
    wait_quiet();
    check("R3 odd count", n_cap, 6);
    check_bytes("R5 backpressure odd", 24'h1235, 6, 0);
  endtask

  task automatic t_err();
    do_reset();
    set_desc(0, 8'h82, 24'h1400, 3);
    fill_buf(24'h1400, 3);
    pulse_demand();
    wait_quiet();
    check("R7 count", n_cap, 3);
    marks("R7", 0, 3, 1'b1, 1'b0);
    check("R7 misc", mem[wi(0, 3)], 16'hC000);
    check("R7 flag", mem[wi(0, 1)], 16'h4200);
    check("R7 int", n_tint, 1);
  endtask

  task automatic t_wrap();
    do_reset();
    ring_log2 = 3'd1;
    set_desc(0, 8'h83, 24'h1000, 2); fill_buf(24'h1000, 2);
    set_desc(1, 8'h83, 24'h1100, 3); fill_buf(24'h1100, 3);
    set_desc(2, 8'h83, 24'h1200, 4); fill_buf(24'h1200, 4);
    pulse_demand();
    wait_quiet();
    check("R8 chained bytes", n_cap, 5);
    check("R8 chained ints", n_tint, 2);
    check_bytes("R8 first", 24'h1000, 2, 0);
    check_bytes("R8 second", 24'h1100, 3, 2);
    check("R8 outside ring flag", mem[wi(2, 1)], 16'h8300);
    check("R8 outside ring misc", mem[wi(2, 3)], 16'h1234);
    set_desc(0, 8'h83, 24'h1300, 1); fill_buf(24'h1300, 1);
    pulse_demand();
    wait_quiet();
    check("R8 wrapped bytes", n_cap, 6);
    check_bytes("R8 wrapped", 24'h1300, 1, 5);
    check("R8 wrapped slot 0 flag", mem[wi(0, 1)], 16'h0300);
    check("R8 outside ring after wrap", mem[wi(2, 1)], 16'h8300);
  endtask

  task automatic t_zero_len();
    do_reset();
    set_desc(0, 8'h83, 24'h1000, 4096);
    fill_buf(24'h1000, 4096);
    check("R3 length field", mem[wi(0, 2)], 16'hF000);
    pulse_demand();
    wait_quiet();
    check("R3 4096 bytes", n_cap, 4096);
    check_bytes("R3 4096", 24'h1000, 4096, 0);
    marks("R4 4096", 0, 4096, 1'b1, 1'b1);
  endtask

  task automatic t_pending();
    do_reset();
    gnt_mode = 2;
    set_desc(0, 8'h03, 24'h1000, 4);
    watch_addr = RING + 24'd2;
    pulse_demand();
    repeat (4) @(negedge clk);
    #2;
    check("R10 request held", mem_req, 1);
    check("R10 address held", mem_addr, RING + 24'd2);
    pulse_demand();
    gnt_mode = 0;
    wait_quiet();
    check("R9 repoll count", flag_reads, 2);
    check("R9 no bytes", n_cap, 0);
  endtask

  initial begin
    t_reset();
    t_host_owned();
    t_single();
    t_odd_bp();
    t_err();
    t_wrap();
    t_zero_len();
    t_pending();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule